// File: doc/BRIEF.md
# Live and Sticky Status Flag Register

This block takes eight one-bit health conditions from an acquisition datapath, covering buffer full and empty conditions, memory occupancy, host-link back-pressure and the operating mode. It keeps two views of them. The live byte mirrors the conditions one clock after they are seen. The history byte remembers every condition that has been high at any time since reset or since the last clear command. Both bytes are available as parallel outputs. A host can also fetch them as a 16-bit frame through a full-duplex bit-serial command port that moves one bit per strobe.

The same serial port carries commands that start and stop acquisition. Because a 16-strobe command is too slow to stop a buffer from overflowing, a separate stop line halts acquisition directly. That line is first passed through a synchroniser. Commands are 16 bits long and are sent most significant bit first. The opcode sits in the top four bits and the other twelve bits are don't-care.

Top module: `stat_flag_reg`

## Requirements
- R1: While `rst_n` is low and after its release, `live_o`, `hist_o`, `rsp_bit_o`, `stop_o` and `run_o` are all 0.
- R2: `live_o` equals the value `flags_i` had at the previous rising clock edge. The bit meanings from 7 down to 0 are: mode, link full, memory empty, memory full, outer buffer empty, outer buffer full, inner buffer empty, inner buffer full.
- R3: A `hist_o` bit is set at the edge where its flag is sampled high, including a flag that is high for only one cycle. It stays set while the flag is low.
- R4: Only the clear opcode (0x2) resets `hist_o`. A read command does not clear it, and neither does any other command.
- R5: When a clear takes effect at an edge where a flag is high, that flag's history bit is left set and all other history bits go to 0.
- R6: A command word is the last 16 bits received on `cmd_bit_i`, most significant bit first, one bit at each edge where `cmd_strobe_i` is high. Cycles with the strobe low change nothing. Bits 11:0 are ignored, and opcodes other than 0x1 to 0x4 have no effect.
- R7: At the edge that completes a read command (opcode 0x1), the response register loads the frame {live byte, history byte}. `rsp_bit_o` presents frame bit 15 from then on, and each later strobe advances it by one bit, so the 16 strobes of the next word deliver the frame most significant bit first.
- R8: `stop_o` follows `stop_i` two clock edges later. From the edge after `stop_o` is high, `run_o` is 0, and a start command received while `stop_o` is high leaves it 0.
- R9: The start opcode (0x3) sets `run_o` and the stop opcode (0x4) clears it, each at the edge that completes the word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flags_i | input | 8 | Status conditions from the datapath |
| cmd_strobe_i | input | 1 | Serial write strobe, one bit per high cycle |
| cmd_bit_i | input | 1 | Serial command bit |
| rsp_bit_o | output | 1 | Serial response bit |
| stop_i | input | 1 | Asynchronous fast stop request |
| stop_o | output | 1 | Synchronised stop |
| run_o | output | 1 | Acquisition enable |
| live_o | output | 8 | Live flag byte |
| hist_o | output | 8 | Sticky history byte |

## Verification
If the history register had a stuck bit or a lost set, it would show on `hist_o` at the next negedge after a sweep value and again in the next serial frame. The bench checks every one of the 256 flag patterns, so no bit position can hide. If the bit counter were off by one, the commands would be framed wrongly: a start word would leave `run_o` unchanged and a read would give a shifted frame, both visible within one word of 16 strobes. An extra or missing synchroniser stage would move the edge of `stop_o` by one cycle, which the bench samples cycle by cycle.

// File: rtl/stat_pkg.sv
// Shared constants for the status flag register: opcodes and flag positions.
// Assumes a 4-bit opcode field at the top of every command word.
package stat_pkg;
    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OP_READ  = 4'h1;
    localparam logic [OP_W-1:0] OP_CLEAR = 4'h2;
    localparam logic [OP_W-1:0] OP_START = 4'h3;
    localparam logic [OP_W-1:0] OP_STOP  = 4'h4;

    // Flag positions within the live and history bytes
    localparam int FL_INNER_FULL  = 0;
    localparam int FL_INNER_EMPTY = 1;
    localparam int FL_OUTER_FULL  = 2;
    localparam int FL_OUTER_EMPTY = 3;
    localparam int FL_MEM_FULL    = 4;
    localparam int FL_MEM_EMPTY   = 5;
    localparam int FL_LINK_FULL   = 6;
    localparam int FL_MODE        = 7;
endpackage

// File: rtl/flag_capture.sv
// Samples the flag vector into a live register and ORs it into a sticky
// history register. Assumes the flags are synchronous to clk. A clear at an
// edge still keeps any flag that is high at that same edge.
module flag_capture #(
    parameter int NUM_FLAGS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] flags_i,
    input  logic                 clr_i,
    output logic [NUM_FLAGS-1:0] live_o,
    output logic [NUM_FLAGS-1:0] hist_o
);
    logic [NUM_FLAGS-1:0] live_q;
    logic [NUM_FLAGS-1:0] hist_q;
    logic [NUM_FLAGS-1:0] hist_base;

    // Base for the history update: zero on clear, otherwise the old value
    always_comb begin
        hist_base = clr_i ? '0 : hist_q;
    end

    // Register the live view and accumulate the history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
            hist_q <= '0;
        end else begin
            live_q <= flags_i;
            hist_q <= hist_base | flags_i;
        end
    end

    assign live_o = live_q;
    assign hist_o = hist_q;

    AST_HIST_COVERS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_q & live_q) == live_q); // R3

    AST_HIST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((hist_q & $past(hist_q)) == $past(hist_q))); // R4
endmodule

// File: rtl/cmd_deser.sv
// Collects serial command bits, most significant first, one per strobe.
// Raises word_valid_o in the cycle whose strobe completes a word and presents
// that word's opcode field. Word framing is held only by reset.
module cmd_deser #(
    parameter int CMD_W = 16,
    parameter int OP_W  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strobe_i,
    input  logic            bit_i,
    output logic            word_valid_o,
    output logic [OP_W-1:0] op_o
);
    localparam int CNT_W = $clog2(CMD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CMD_W - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CMD_W-2:0] sh_q;
    logic [CMD_W-1:0] word;

    // The word as it stands once the current bit is appended
    always_comb begin
        word         = {sh_q, bit_i};
        word_valid_o = strobe_i && (cnt_q == LAST);
        op_o         = word[CMD_W-1 -: OP_W];
    end

    // Count strobes and shift in the bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (strobe_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            sh_q  <= word[CMD_W-2:0];
        end
    end

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && cnt_q == LAST) |=> (cnt_q == '0)); // R6

    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/stop_sync.sv
// Multi-stage synchroniser for the asynchronous stop request. The output
// follows the input STAGES edges later and stays high while the input does.
module stop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rsp_shifter.sv
// Parallel-load, serial-out response register. Load takes priority over
// shift. The output is always the most significant bit.
module rsp_shifter #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               shift_i,
    output logic               bit_o
);
    logic [FRAME_W-1:0] sh_q;

    // Load a fresh frame, or move the next bit out on a strobe
    always_ff @(posedge clk) begin
        if (!rst_n)       sh_q <= '0;
        else if (load_i)  sh_q <= frame_i;
        else if (shift_i) sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
    end

    assign bit_o = sh_q[FRAME_W-1];

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !shift_i) |=> $stable(sh_q)); // R6
endmodule

// File: rtl/stat_flag_reg.sv
// Top of the status flag register. Decodes the serial opcodes into clear,
// read, start and stop actions, controls the acquisition enable, and ties
// together capture, deserialiser, response shifter and stop synchroniser.
// Assumes cmd_strobe_i and cmd_bit_i are synchronous to clk.
module stat_flag_reg
    import stat_pkg::*;
#(
    parameter int NUM_FLAGS   = 8,
    parameter int CMD_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] flags_i,
    input  logic                 cmd_strobe_i,
    input  logic                 cmd_bit_i,
    output logic                 rsp_bit_o,
    input  logic                 stop_i,
    output logic                 stop_o,
    output logic                 run_o,
    output logic [NUM_FLAGS-1:0] live_o,
    output logic [NUM_FLAGS-1:0] hist_o
);
    localparam int FRAME_W = 2 * NUM_FLAGS;

    logic            word_valid;
    logic [OP_W-1:0] op;
    logic            do_read, do_clear, do_start, do_stop;
    logic            stop_s;
    logic            run_q;
    logic [NUM_FLAGS-1:0] live, hist;

    cmd_deser #(.CMD_W(CMD_W), .OP_W(OP_W)) u_deser (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_i     (cmd_strobe_i),
        .bit_i        (cmd_bit_i),
        .word_valid_o (word_valid),
        .op_o         (op)
    );

    // Turn a completed word into one action strobe
    always_comb begin
        do_read  = word_valid && (op == OP_READ);
        do_clear = word_valid && (op == OP_CLEAR);
        do_start = word_valid && (op == OP_START);
        do_stop  = word_valid && (op == OP_STOP);
    end

    flag_capture #(.NUM_FLAGS(NUM_FLAGS)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i (flags_i),
        .clr_i   (do_clear),
        .live_o  (live),
        .hist_o  (hist)
    );

    rsp_shifter #(.FRAME_W(FRAME_W)) u_rsp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (do_read),
        .frame_i ({live, hist}),
        .shift_i (cmd_strobe_i),
        .bit_o   (rsp_bit_o)
    );

    stop_sync #(.STAGES(SYNC_STAGES)) u_stop (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (stop_i),
        .sync_o  (stop_s)
    );

    // Acquisition enable: the stop line wins over any command
    always_ff @(posedge clk) begin
        if (!rst_n)        run_q <= 1'b0;
        else if (stop_s)   run_q <= 1'b0;
        else if (do_start) run_q <= 1'b1;
        else if (do_stop)  run_q <= 1'b0;
    end

    assign run_o  = run_q;
    assign stop_o = stop_s;
    assign live_o = live;
    assign hist_o = hist;

    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_s |=> !run_q); // R8

    AST_START_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (do_start && !stop_s) |=> run_q); // R9

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({do_read, do_clear, do_start, do_stop})); // R6
endmodule

// File: tb/stat_flag_reg_test.sv
module stat_flag_reg_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] flags = '0;
    logic strobe = 1'b0, cbit = 1'b0, stop_in = 1'b0;
    logic rsp, stop_out, run;
    logic [7:0] live, hist;

    int checks = 0;
    int errors = 0;
    logic [7:0]  hmodel;
    logic [15:0] got;

    always #(CLK_PERIOD/2) clk = ~clk;

    stat_flag_reg uut (
        .clk(clk), .rst_n(rst_n), .flags_i(flags),
        .cmd_strobe_i(strobe), .cmd_bit_i(cbit), .rsp_bit_o(rsp),
        .stop_i(stop_in), .stop_o(stop_out), .run_o(run),
        .live_o(live), .hist_o(hist)
    );

    task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Send one word MSB first; capture rsp before each strobe edge
    task automatic send(input logic [15:0] w, output logic [15:0] r);
        for (int i = 15; i >= 0; i--) begin
            r[i]   = rsp;
            strobe = 1'b1;
            cbit   = w[i];
            step();
            strobe = 1'b0;
        end
    endtask

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected <%0d cycles", WATCHDOG, WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(); step();
        // R1: reset state while held
        chk({live, hist, rsp, stop_out, run} == '0, "R1 in reset", {live, hist}, 16'h0);
        rst_n = 1'b1;
        step();
        chk({live, hist, rsp, stop_out, run} == '0, "R1 after reset", {live, hist}, 16'h0);

        // R2 R3: sweep all 256 patterns, expected history ORed arithmetically
        hmodel = '0;
        for (int v = 0; v < 256; v++) begin
            flags = 8'(v);
            step();
            hmodel = hmodel | 8'(v);
            chk(live == 8'(v), "R2 live", {8'h0, live}, 16'(v));
            chk(hist == hmodel, "R3 hist", {8'h0, hist}, {8'h0, hmodel});
            if (v % 64 == 63) begin
                // R5: clear while flags held -> history equals held value
                send(16'h2000, got);
                hmodel = 8'(v);
                chk(hist == hmodel, "R5 clear with flags high", {8'h0, hist}, {8'h0, hmodel});
            end
        end

        // R4: clear with flags low empties history
        flags = 8'h00;
        send(16'h2ABC, got);
        chk(hist == 8'h00, "R4 clear", {8'h0, hist}, 16'h0);

        // R3: one-cycle pulse on the mode flag (bit 7) is remembered
        flags = 8'h80;
        step();
        flags = 8'h00;
        for (int k = 0; k < 10; k++) step();
        chk(hist == 8'h80, "R3 pulse sticky", {8'h0, hist}, 16'h0080);
        chk(live == 8'h00, "R2 live after pulse", {8'h0, live}, 16'h0);

        // R5: only link-full (bit 6) is high at the clear edge
        flags = 8'h41;
        step();
        flags = 8'h40;
        send(16'h2000, got);
        chk(hist == 8'h40, "R5 clear keeps same-cycle flag", {8'h0, hist}, 16'h0040);

        // R7: read frame {live, hist}, read does not clear, idle keeps frame
        flags = 8'h21;
        step();
        send(16'h1000, got);
        for (int k = 0; k < 20; k++) step();
        send(16'h0000, got);
        chk(got == 16'h2161, "R7 frame after idle", got, 16'h2161);
        chk(hist == 8'h61, "R4 read keeps history", {8'h0, hist}, 16'h0061);

        // R6: unknown opcodes and ignored low bits change nothing
        send(16'hF000, got);
        send(16'h5ABC, got);
        send(16'h0FFF, got);
        chk(hist == 8'h61 && run == 1'b0, "R6 unknown opcodes", {7'h0, run, hist}, 16'h0061);

        // R9: start and stop commands
        send(16'h3FFF, got);
        chk(run == 1'b1, "R9 start", {15'h0, run}, 16'h1);
        send(16'h4000, got);
        chk(run == 1'b0, "R9 stop command", {15'h0, run}, 16'h0);
        send(16'h3000, got);

        // R8: stop line latency and priority
        stop_in = 1'b1;
        step();
        chk(stop_out == 1'b0, "R8 stop after one edge", {15'h0, stop_out}, 16'h0);
        step();
        chk(stop_out == 1'b1 && run == 1'b1, "R8 stop after two edges", {14'h0, stop_out, run}, 16'h3);
        step();
        chk(run == 1'b0, "R8 run cleared", {15'h0, run}, 16'h0);
        send(16'h3000, got);
        chk(run == 1'b0, "R8 start ignored while stopped", {15'h0, run}, 16'h0);
        stop_in = 1'b0;
        step();
        chk(stop_out == 1'b1, "R8 release after one edge", {15'h0, stop_out}, 16'h1);
        step();
        chk(stop_out == 1'b0, "R8 release after two edges", {15'h0, stop_out}, 16'h0);
        send(16'h3000, got);
        chk(run == 1'b1, "R9 start after release", {15'h0, run}, 16'h1);

        // R7: second frame with different contents, full duplex with a stop command
        flags = 8'h9C;
        step();
        send(16'h1000, got);
        send(16'h4000, got);
        chk(got == 16'h9CFD, "R7 frame two", got, 16'h9CFD);
        chk(run == 1'b0, "R9 stop during readout", {15'h0, run}, 16'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule